// File: doc/BRIEF.md
# Interrupt Mask and Status Unit

This block collects interrupt events for a serial port and decides which of them reach the processor. The datapath sends single-cycle event pulses, and each pulse sets a sticky status bit. Software controls a mask register, but only through two write-only ports. Writing ones to the arm port sets mask bits. Writing ones to the disarm port clears them. The interrupt line is a registered OR of the status bits whose mask bit is set. Software clears a status bit by writing a one to that bit position of the status register.

A separate live view returns the present levels of the FIFO conditions, whatever the mask holds. This lets a polling routine see conditions that are not allowed to interrupt. The register port is a plain write strobe with a word select and a combinational read path. Status and mask keep the same bit layout. Bit 0 is receive trigger, 1 receive empty, 2 receive full, 3 transmit empty, 4 transmit full, 5 overrun, 6 framing error, 7 parity error and 8 receive timeout. Bits 9 to 12 belong to the valid field but have no event source.

Top module: `irq_mask_unit`

## Requirements
- R1: After a synchronous active-low reset, the mask, the status and `irq_o` are all 0.
- R2: A write to select 0 (arm) sets every mask bit whose data bit is 1 on the clock edge of the write. Bits written as 0 keep their old value.
- R3: A write to select 1 (disarm) clears every mask bit whose data bit is 1. Bits written as 0 keep their old value. Inside the mask bank, a clear beats a set of the same bit in the same cycle.
- R4: Reads of select 0 and select 1 always return 0. Select 2 returns the mask, and a write to select 2 leaves the mask unchanged.
- R5: An event pulse on bit i sets status bit i on that clock edge, whether or not the bit is masked. The bit stays set until software clears it.
- R6: A write to select 3 clears every status bit whose data bit is 1. Bits written as 0 are kept.
- R7: If an event on a bit arrives in the same cycle as a clear of that bit, the bit stays set.
- R8: `irq_o` is registered. One cycle after status or mask changes, it equals the OR of the bits set in both.
- R9: Select 4 returns the live condition inputs on bits 0 to 8 with no delay, whatever the mask holds.
- R10: Only bits 0 to 12 (a 13-bit field) are stored in the mask. Writing data bits 13 to 31 has no effect, and those bits always read as 0. Status bits 9 to 12 always read as 0.
- R11: Selects 5 to 7 read as 0, and writes to them change neither the mask nor the status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for one cycle |
| sel | input | 3 | Register word select |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `sel`, combinational |
| evt_i | input | 9 | Single-cycle event pulses from the datapath |
| live_i | input | 9 | Live FIFO condition levels |
| irq_o | output | 1 | Interrupt request, registered |

## Verification
The bench targets the clear-versus-event collision. A design that let the clear win would silently lose an interrupt that arrives while software acknowledges an older one. It writes partial patterns to the arm and disarm ports and reads the mask back. A design that loaded the data instead of merging it would corrupt bits that were never named. It also times the interrupt line to the exact cycle, once after a masked event is later unmasked and once after a clear. This catches an unregistered path or a path that uses the raw status instead of the masked status. Finally, it checks that the live view and the unused selects stay independent of the mask.

// File: rtl/imu_pkg.sv
// Package: register selects shared by the interrupt mask unit and its checker.
// Assumes a 3-bit word select on the register port.
package imu_pkg;
    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_ARM    = 3'd0,
        SEL_DISARM = 3'd1,
        SEL_MASK   = 3'd2,
        SEL_STAT   = 3'd3,
        SEL_LIVE   = 3'd4
    } reg_sel_e;
endpackage

// File: rtl/imu_mask_bank.sv
// Mask bank: one flop per valid bit, updated from set and clear vectors.
// Assumes set and clear come already decoded. A clear beats a set of the same bit.
module imu_mask_bank #(
    parameter int VALID_W = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [VALID_W-1:0] set_vec,
    input  logic [VALID_W-1:0] clr_vec,
    output logic [VALID_W-1:0] mask_q
);
    for (genvar b = 0; b < VALID_W; b++) begin : g_bit
        // Hold, set or clear one mask bit.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mask_q[b] <= 1'b0;
            else if (clr_vec[b])
                mask_q[b] <= 1'b0;
            else if (set_vec[b])
                mask_q[b] <= 1'b1;
        end
    end
endmodule

// File: rtl/imu_status_bank.sv
// Status bank: sticky bits set by event pulses and cleared by a write of one.
// Assumes events are pulses on bits below NUM_SRC. Higher valid bits are tied to 0.
module imu_status_bank #(
    parameter int VALID_W = 13,
    parameter int NUM_SRC = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt,
    input  logic [VALID_W-1:0] clr_vec,
    output logic [VALID_W-1:0] stat_q
);
    for (genvar b = 0; b < VALID_W; b++) begin : g_bit
        if (b < NUM_SRC) begin : g_src
            // An event wins over a clear in the same cycle.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stat_q[b] <= 1'b0;
                else if (evt[b])
                    stat_q[b] <= 1'b1;
                else if (clr_vec[b])
                    stat_q[b] <= 1'b0;
            end
        end else begin : g_nosrc
            assign stat_q[b] = 1'b0;
        end
    end
endmodule

// File: rtl/imu_irq_gen.sv
// Interrupt generator: registers the OR of the status bits that are also set in the mask.
// Assumes status and mask share the same bit layout.
module imu_irq_gen #(
    parameter int VALID_W = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [VALID_W-1:0] stat_q,
    input  logic [VALID_W-1:0] mask_q,
    output logic               irq_o
);
    // Register the masked reduction.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_o <= 1'b0;
        else
            irq_o <= |(stat_q & mask_q);
    end
endmodule

// File: rtl/imu_read_mux.sv
// Read mux: selects the register view for the current word select, zero-extended.
// Assumes DATA_W > VALID_W >= NUM_SRC. The arm, disarm and unused selects read as 0.
module imu_read_mux
    import imu_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int VALID_W = 13,
    parameter int NUM_SRC = 9
) (
    input  logic [SEL_W-1:0]   sel,
    input  logic [VALID_W-1:0] mask_q,
    input  logic [VALID_W-1:0] stat_q,
    input  logic [NUM_SRC-1:0] live,
    output logic [DATA_W-1:0]  rdata
);
    localparam int PAD_V = DATA_W - VALID_W;
    localparam int PAD_S = DATA_W - NUM_SRC;

    // Choose the view that matches the select.
    always_comb begin
        rdata = '0;
        case (reg_sel_e'(sel))
            SEL_MASK: rdata = {{PAD_V{1'b0}}, mask_q};
            SEL_STAT: rdata = {{PAD_V{1'b0}}, stat_q};
            SEL_LIVE: rdata = {{PAD_S{1'b0}}, live};
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_mask_unit.sv
// Interrupt mask and status unit: decodes register writes into mask set/clear and
// status clear vectors, and holds the sticky status and the registered interrupt.
// Assumes one register write per cycle and single-cycle event pulses.
module irq_mask_unit
    import imu_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int VALID_W = 13,
    parameter int NUM_SRC = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   sel,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic [NUM_SRC-1:0] live_i,
    output logic               irq_o
);
    logic [VALID_W-1:0] mask_q;
    logic [VALID_W-1:0] stat_q;
    logic [VALID_W-1:0] arm_vec;
    logic [VALID_W-1:0] disarm_vec;
    logic [VALID_W-1:0] ack_vec;
    logic               unused_hi;

    assign unused_hi = ^wdata[DATA_W-1:VALID_W];

    // Decode the write strobe into per-register bit vectors.
    always_comb begin
        arm_vec    = '0;
        disarm_vec = '0;
        ack_vec    = '0;
        if (wr_en) begin
            case (reg_sel_e'(sel))
                SEL_ARM:    arm_vec    = wdata[VALID_W-1:0];
                SEL_DISARM: disarm_vec = wdata[VALID_W-1:0];
                SEL_STAT:   ack_vec    = wdata[VALID_W-1:0];
                default:    ;
            endcase
        end
    end

    imu_mask_bank #(.VALID_W(VALID_W)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (arm_vec),
        .clr_vec (disarm_vec),
        .mask_q  (mask_q)
    );

    imu_status_bank #(.VALID_W(VALID_W), .NUM_SRC(NUM_SRC)) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt_i),
        .clr_vec (ack_vec),
        .stat_q  (stat_q)
    );

    imu_irq_gen #(.VALID_W(VALID_W)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .stat_q (stat_q),
        .mask_q (mask_q),
        .irq_o  (irq_o)
    );

    imu_read_mux #(.DATA_W(DATA_W), .VALID_W(VALID_W), .NUM_SRC(NUM_SRC)) u_rd (
        .sel    (sel),
        .mask_q (mask_q),
        .stat_q (stat_q),
        .live   (live_i),
        .rdata  (rdata)
    );
endmodule

// File: rtl/imu_checker.sv
// Checker: temporal properties of the interrupt mask unit, bound to the top module.
// Assumes the reset is synchronous and active low.
module imu_checker
    import imu_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int VALID_W = 13,
    parameter int NUM_SRC = 9
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [SEL_W-1:0]   sel,
    input logic [DATA_W-1:0]  wdata,
    input logic [DATA_W-1:0]  rdata,
    input logic [NUM_SRC-1:0] evt_i,
    input logic [VALID_W-1:0] mask_q,
    input logic [VALID_W-1:0] stat_q,
    input logic               irq_o
);
    localparam logic [VALID_W-1:0] SRC_BITS = VALID_W'((1 << NUM_SRC) - 1);

    // R2: written ones are set one cycle later.
    a_r2_arm_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_ARM) |=>
            ((mask_q & $past(wdata[VALID_W-1:0])) == $past(wdata[VALID_W-1:0])));

    // R3: written ones are cleared one cycle later.
    a_r3_disarm_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_DISARM) |=> ((mask_q & $past(wdata[VALID_W-1:0])) == '0));

    // R4: the write-only selects read as zero.
    a_r4_wo_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_ARM || sel == SEL_DISARM) |-> (rdata == '0));

    // R4: the mask changes only through the arm or disarm selects.
    a_r4_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (sel == SEL_ARM || sel == SEL_DISARM)) |=> $stable(mask_q));

    // R5 and R7: an event bit is set after its edge, even when a clear comes with it.
    a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((stat_q & VALID_W'($past(evt_i))) == VALID_W'($past(evt_i))));

    // R6: acknowledged bits with no event are cleared.
    a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_STAT) |=>
            ((stat_q & $past(wdata[VALID_W-1:0]) & ~VALID_W'($past(evt_i))) == '0));

    // R8: the interrupt follows the masked status with one cycle of delay.
    a_r8_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(|(stat_q & mask_q))));

    // R10: status bits without a source stay clear.
    a_r10_no_phantom: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> ((stat_q & ~SRC_BITS) == '0));
endmodule

bind irq_mask_unit imu_checker #(
    .DATA_W  (DATA_W),
    .VALID_W (VALID_W),
    .NUM_SRC (NUM_SRC)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .sel    (sel),
    .wdata  (wdata),
    .rdata  (rdata),
    .evt_i  (evt_i),
    .mask_q (mask_q),
    .stat_q (stat_q),
    .irq_o  (irq_o)
);

// File: tb/sim_irq_mask_unit.sv
// Directed bench for irq_mask_unit. Inputs change on the falling edge.
module sim_irq_mask_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  sel = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [8:0]  evt_i = '0;
    logic [8:0]  live_i = '0;
    logic        irq_o;
    int          n_chk = 0;
    int          n_bad = 0;
    logic        done = 1'b0;

    always #2 clk = ~clk;

    irq_mask_unit u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel(sel), .wdata(wdata),
        .rdata(rdata), .evt_i(evt_i), .live_i(live_i), .irq_o(irq_o)
    );

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(logic [2:0] s, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; sel = s; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(logic [2:0] s, output logic [31:0] d);
        @(negedge clk);
        sel = s;
        #1 d = rdata;
    endtask

    task automatic pulse(logic [8:0] e);
        @(negedge clk);
        evt_i = e;
        @(negedge clk);
        evt_i = '0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(3'd2, v); check("R1 mask", v, 32'h0);
        rd(3'd3, v); check("R1 status", v, 32'h0);
        check("R1 irq", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_arm();
        logic [31:0] v;
        wr(3'd0, 32'h0000_0005); rd(3'd2, v); check("R2 arm 0x005", v, 32'h005);
        wr(3'd0, 32'h0000_0100); rd(3'd2, v); check("R2 arm merge", v, 32'h105);
        wr(3'd0, 32'hFFFF_FFFF); rd(3'd2, v); check("R10 width", v, 32'h1FFF);
    endtask

    task automatic t_disarm();
        logic [31:0] v;
        wr(3'd1, 32'h0000_0004); rd(3'd2, v); check("R3 disarm one", v, 32'h1FFB);
        rd(3'd0, v); check("R4 arm reads 0", v, 32'h0);
        rd(3'd1, v); check("R4 disarm reads 0", v, 32'h0);
        wr(3'd2, 32'h0000_0000); rd(3'd2, v); check("R4 mask ro", v, 32'h1FFB);
        wr(3'd1, 32'hFFFF_FFFF); rd(3'd2, v); check("R3 disarm all", v, 32'h0);
    endtask

    task automatic t_event();
        logic [31:0] v;
        pulse(9'h008);
        rd(3'd3, v); check("R5 masked event", v, 32'h008);
        check("R8 masked no irq", {31'b0, irq_o}, 32'h0);
        wr(3'd0, 32'h0000_0008);
        check("R8 irq not yet", {31'b0, irq_o}, 32'h0);
        @(posedge clk); @(negedge clk);
        check("R8 irq after unmask", {31'b0, irq_o}, 32'h1);
        pulse(9'h100);
        rd(3'd3, v); check("R5 sticky", v, 32'h108);
    endtask

    task automatic t_ack();
        logic [31:0] v;
        wr(3'd3, 32'h0000_0008);
        rd(3'd3, v); check("R6 ack one", v, 32'h100);
        @(posedge clk); @(negedge clk);
        check("R8 irq drops", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_collide();
        logic [31:0] v;
        @(negedge clk);
        wr_en = 1'b1; sel = 3'd3; wdata = 32'h0000_0120; evt_i = 9'h020;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0; evt_i = '0;
        rd(3'd3, v); check("R7 event beats ack", v, 32'h020);
    endtask

    task automatic t_live();
        logic [31:0] v;
        live_i = 9'h1A5;
        rd(3'd4, v); check("R9 live view", v, 32'h1A5);
        live_i = 9'h042;
        #1 check("R9 live follows", rdata, 32'h042);
        rd(3'd3, v); check("R9 status untouched", v, 32'h020);
    endtask

    task automatic t_unused();
        logic [31:0] v;
        wr(3'd6, 32'hFFFF_FFFF);
        rd(3'd6, v); check("R11 unused reads 0", v, 32'h0);
        rd(3'd2, v); check("R11 mask kept", v, 32'h008);
        rd(3'd3, v); check("R11 status kept", v, 32'h020);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_arm();
        t_disarm();
        t_event();
        t_ack();
        t_collide();
        t_live();
        t_unused();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule